// File: doc/BRIEF.md
# Digital Phase-Locked Loop with Phase-Accumulator Oscillator

This block is an all-digital phase-locked loop that runs on one system clock. A reference input is synchronised and compared against a feedback tick. The feedback tick comes from dividing the oscillator output down to the expected reference rate. The signed phase error, counted in system clocks, passes through a first-order lowpass filter. The filter output trims the increment of a phase-accumulator oscillator, whose most significant bit is the primary output clock. Counters driven by that clock produce binary-divided clocks and an 8 kHz-class frame pulse.

A two-bit rate select tells the loop which reference to expect: frame rate, T1 rate or E1 rate. It sets the feedback divide ratio, so all three references lead to the same oscillator frequency. Two external controls override closed-loop operation. Holdover freezes the current frequency word. Freerun forces the nominal word and clears the correction. A lock flag reports when the phase error has stayed inside a window for a chosen number of consecutive reference periods. The loop gain shifts and the divide ratios are parameters, so a simulation can use scaled-down rates.

Top module: `adpll_top`

## Requirements
- R1: While reset is asserted, `dco_clk`, every `div_clk` bit, `fb_tick`, `frame_pulse` and `locked` are 0, and `freq_word` equals the nominal word `NOM_WORD`.
- R2: The oscillator adds `freq_word` to an `ACC_W`-bit accumulator every system clock, and `dco_clk` is the accumulator's top bit. With the nominal word 2^ACC_W/4, `dco_clk` has a period of 4 system clocks.
- R3: `div_clk[i]` has a period of 2^(i+1) oscillator periods, and each rising edge of it falls in the same cycle as a rising edge of `dco_clk`.
- R4: `frame_pulse` is high for exactly one system clock, once every `FRAME_DIV` oscillator periods.
- R5: `fb_tick` is a one-cycle pulse every N oscillator periods. N is `FB_DIV_FRM` for `fsel`=00 and for the reserved code 11, `FB_DIV_T1` for 01, and `FB_DIV_E1` for 10.
- R6: From the cycle after `freerun` is sampled high, `freq_word` equals `NOM_WORD`, whatever the reference does.
- R7: While `holdover` is high and `freerun` is low, `freq_word` does not change, even if the reference changes or disappears.
- R8: Each phase-error measurement has a magnitude no larger than `pd_limit`. As a result, `freq_word` never leaves `NOM_WORD ± (pd_limit << KP_SHIFT)`.
- R9: `locked` rises on the `lock_count`-th consecutive measurement whose magnitude is below `lock_thresh`. It falls on the first measurement at or above the threshold, so a threshold of 0 never locks.
- R10: The error is positive when the reference edge comes before the feedback edge. A reference that runs faster than the feedback therefore drives `freq_word` above `NOM_WORD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Reference clock, asynchronous to `clk` |
| fsel | input | 2 | Expected reference rate: 00 frame, 01 T1, 10 E1, 11 as 00 |
| holdover | input | 1 | Freeze the frequency word |
| freerun | input | 1 | Force the nominal word and clear the correction |
| pd_limit | input | ERR_W-1 | Saturation limit of the phase-error count |
| lock_thresh | input | ERR_W-1 | Error magnitude must be below this value to count as good |
| lock_count | input | LOCK_W | Number of consecutive good measurements needed for lock |
| dco_clk | output | 1 | Oscillator output clock |
| div_clk | output | NUM_DIV | Binary-divided oscillator clocks |
| fb_tick | output | 1 | Feedback divider pulse at the reference rate |
| frame_pulse | output | 1 | One-cycle frame pulse |
| locked | output | 1 | Lock indicator |
| freq_word | output | ACC_W | Current oscillator increment |

## Verification
The checker watches every cycle for the following:
- the error bound against `pd_limit`;
- the frozen word during holdover;
- the nominal word during freerun;
- unlocking on a bad measurement;
- single-cycle widths of the feedback and frame pulses;
- alignment of the divided clocks with the oscillator edge.

Some behaviours appear only in the bench's scenarios and are measured there as edge-to-edge intervals:
- the divide ratio that each rate-select code picks;
- the oscillator, divided-clock and frame periods;
- the count of good periods before lock;
- the direction in which the closed loop pulls the word when the reference runs fast.

// File: rtl/adpll_pkg.sv
package adpll_pkg;

  typedef enum logic [1:0] {
    PD_IDLE     = 2'd0,
    PD_REF_LEAD = 2'd1,
    PD_FB_LEAD  = 2'd2
  } pd_state_e;

  localparam logic [1:0] FSEL_FRAME = 2'b00;
  localparam logic [1:0] FSEL_T1    = 2'b01;
  localparam logic [1:0] FSEL_E1    = 2'b10;

endpackage

// File: rtl/adpll_phase_det.sv
module adpll_phase_det
  import adpll_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_in,
  input  logic                    fb_tick,
  input  logic [ERR_W-2:0]        limit,
  output logic                    err_valid,
  output logic signed [ERR_W-1:0] err
);

  logic ref_s1_q, ref_s2_q, ref_s3_q;
  logic ref_rise;

  pd_state_e              st_q, st_n;
  logic [ERR_W-2:0]       cnt_q, cnt_n;
  logic                   vld_q, vld_n;
  logic signed [ERR_W-1:0] err_q, err_n;

  function automatic logic [ERR_W-2:0] sat_inc(input logic [ERR_W-2:0] v,
                                               input logic [ERR_W-2:0] lim);
    return (v >= lim) ? lim : v + 1'b1;
  endfunction

  // two-flop synchroniser plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s1_q <= 1'b0;
      ref_s2_q <= 1'b0;
      ref_s3_q <= 1'b0;
    end else begin
      ref_s1_q <= ref_in;
      ref_s2_q <= ref_s1_q;
      ref_s3_q <= ref_s2_q;
    end
  end

  assign ref_rise = ref_s2_q & ~ref_s3_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    vld_n = 1'b0;
    err_n = err_q;
    case (st_q)
      PD_IDLE: begin
        if (ref_rise && fb_tick) begin
          vld_n = 1'b1;
          err_n = '0;
        end else if (ref_rise) begin
          st_n  = PD_REF_LEAD;
          cnt_n = sat_inc('0, limit);
        end else if (fb_tick) begin
          st_n  = PD_FB_LEAD;
          cnt_n = sat_inc('0, limit);
        end
      end
      PD_REF_LEAD: begin
        if (fb_tick) begin
          vld_n = 1'b1;
          err_n = $signed({1'b0, cnt_q});
          st_n  = PD_IDLE;
        end else begin
          cnt_n = sat_inc(cnt_q, limit);
        end
      end
      PD_FB_LEAD: begin
        if (ref_rise) begin
          vld_n = 1'b1;
          err_n = -$signed({1'b0, cnt_q});
          st_n  = PD_IDLE;
        end else begin
          cnt_n = sat_inc(cnt_q, limit);
        end
      end
      default: st_n = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PD_IDLE;
      cnt_q <= '0;
      vld_q <= 1'b0;
      err_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      vld_q <= vld_n;
      err_q <= err_n;
    end
  end

  assign err_valid = vld_q;
  assign err       = err_q;

endmodule

// File: rtl/adpll_loop_filt.sv
module adpll_loop_filt #(
  parameter int ERR_W     = 8,
  parameter int CORR_W    = 16,
  parameter int KP_SHIFT  = 6,
  parameter int LPF_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_valid,
  input  logic signed [ERR_W-1:0]  err,
  input  logic                     holdover,
  input  logic                     freerun,
  output logic signed [CORR_W-1:0] corr
);

  localparam int WW = CORR_W + 2;

  logic signed [WW-1:0]     err_ext, target, corr_ext, diff, step;
  logic signed [CORR_W-1:0] corr_q, corr_n;
  logic                     upd_en;

  always_comb begin
    err_ext  = WW'(err);
    target   = err_ext <<< KP_SHIFT;
    corr_ext = WW'(corr_q);
    diff     = target - corr_ext;
    step     = diff >>> LPF_SHIFT;
    upd_en   = freerun | (err_valid & ~holdover);
    if (freerun) corr_n = '0;
    else         corr_n = CORR_W'(corr_ext + step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      corr_q <= '0;
    else if (upd_en) corr_q <= corr_n;
  end

  assign corr = corr_q;

endmodule

// File: rtl/adpll_dco.sv
module adpll_dco
  import adpll_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int NUM_DIV    = 3,
  parameter int CNT_W      = 16,
  parameter int FB_DIV_FRM = 2048,
  parameter int FB_DIV_T1  = 11,
  parameter int FB_DIV_E1  = 8,
  parameter int FRAME_DIV  = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   freq_word,
  input  logic [1:0]         fsel,
  output logic               dco_clk,
  output logic [NUM_DIV-1:0] div_clk,
  output logic               fb_tick,
  output logic               frame_pulse
);

  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_DIV - 1);

  logic [ACC_W-1:0] acc_q, acc_n;
  logic             rise;
  logic [CNT_W-1:0] ratio, fb_cnt_q, fb_cnt_n, fr_cnt_q, fr_cnt_n;
  logic             fb_wrap, fr_wrap, fb_tick_q, fr_pulse_q;
  logic [NUM_DIV-1:0] tog;

  always_comb begin
    acc_n = acc_q + freq_word;
    rise  = ~acc_q[ACC_W-1] & acc_n[ACC_W-1];
    case (fsel)
      FSEL_T1: ratio = CNT_W'(FB_DIV_T1);
      FSEL_E1: ratio = CNT_W'(FB_DIV_E1);
      default: ratio = CNT_W'(FB_DIV_FRM);
    endcase
    fb_wrap  = (fb_cnt_q >= ratio - 1'b1);
    fb_cnt_n = fb_wrap ? '0 : fb_cnt_q + 1'b1;
    fr_wrap  = (fr_cnt_q >= FRAME_LAST);
    fr_cnt_n = fr_wrap ? '0 : fr_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      fb_cnt_q   <= '0;
      fr_cnt_q   <= '0;
      fb_tick_q  <= 1'b0;
      fr_pulse_q <= 1'b0;
    end else begin
      acc_q      <= acc_n;
      fb_tick_q  <= rise & fb_wrap;
      fr_pulse_q <= rise & fr_wrap;
      if (rise) begin
        fb_cnt_q <= fb_cnt_n;
        fr_cnt_q <= fr_cnt_n;
      end
    end
  end

  // ripple-enable chain of toggle stages, one per divided clock
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    logic stage_q;
    if (i == 0) begin : g_first
      assign tog[i] = rise;
    end else begin : g_next
      assign tog[i] = tog[i-1] & div_clk[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q <= 1'b0;
      else if (tog[i]) stage_q <= ~stage_q;
    end
    assign div_clk[i] = stage_q;
  end

  assign dco_clk     = acc_q[ACC_W-1];
  assign fb_tick     = fb_tick_q;
  assign frame_pulse = fr_pulse_q;

endmodule

// File: rtl/adpll_lock_det.sv
module adpll_lock_det #(
  parameter int ERR_W  = 8,
  parameter int LOCK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err,
  input  logic [ERR_W-2:0]        thresh,
  input  logic [LOCK_W-1:0]       need,
  output logic                    locked
);

  logic [ERR_W-1:0]  mag;
  logic              good;
  logic [LOCK_W-1:0] cnt_q, cnt_n;
  logic              lock_q, lock_n;

  always_comb begin
    mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    good = (mag < {1'b0, thresh});
    if (good) begin
      cnt_n  = (cnt_q < need) ? cnt_q + 1'b1 : cnt_q;
      lock_n = (cnt_n >= need);
    end else begin
      cnt_n  = '0;
      lock_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (err_valid) begin
      cnt_q  <= cnt_n;
      lock_q <= lock_n;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/adpll_top.sv
module adpll_top #(
  parameter int ACC_W      = 16,
  parameter int NOM_WORD   = 16384,
  parameter int NUM_DIV    = 3,
  parameter int CNT_W      = 16,
  parameter int FB_DIV_FRM = 2048,
  parameter int FB_DIV_T1  = 11,
  parameter int FB_DIV_E1  = 8,
  parameter int FRAME_DIV  = 2048,
  parameter int ERR_W      = 8,
  parameter int LOCK_W     = 8,
  parameter int KP_SHIFT   = 6,
  parameter int LPF_SHIFT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic [1:0]         fsel,
  input  logic               holdover,
  input  logic               freerun,
  input  logic [ERR_W-2:0]   pd_limit,
  input  logic [ERR_W-2:0]   lock_thresh,
  input  logic [LOCK_W-1:0]  lock_count,
  output logic               dco_clk,
  output logic [NUM_DIV-1:0] div_clk,
  output logic               fb_tick,
  output logic               frame_pulse,
  output logic               locked,
  output logic [ACC_W-1:0]   freq_word
);

  localparam logic [ACC_W-1:0] NOM_L = ACC_W'(NOM_WORD);

  logic                    rs1_q, rs2_q, srst_n;
  logic                    err_valid;
  logic signed [ERR_W-1:0] pd_err;
  logic signed [ACC_W-1:0] corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  adpll_phase_det #(.ERR_W(ERR_W)) u_pd (
    .clk(clk), .rst_n(srst_n), .ref_in(ref_in), .fb_tick(fb_tick),
    .limit(pd_limit), .err_valid(err_valid), .err(pd_err)
  );

  adpll_loop_filt #(.ERR_W(ERR_W), .CORR_W(ACC_W), .KP_SHIFT(KP_SHIFT),
                    .LPF_SHIFT(LPF_SHIFT)) u_lf (
    .clk(clk), .rst_n(srst_n), .err_valid(err_valid), .err(pd_err),
    .holdover(holdover), .freerun(freerun), .corr(corr)
  );

  assign freq_word = NOM_L + $unsigned(corr);

  adpll_dco #(.ACC_W(ACC_W), .NUM_DIV(NUM_DIV), .CNT_W(CNT_W),
              .FB_DIV_FRM(FB_DIV_FRM), .FB_DIV_T1(FB_DIV_T1),
              .FB_DIV_E1(FB_DIV_E1), .FRAME_DIV(FRAME_DIV)) u_dco (
    .clk(clk), .rst_n(srst_n), .freq_word(freq_word), .fsel(fsel),
    .dco_clk(dco_clk), .div_clk(div_clk), .fb_tick(fb_tick),
    .frame_pulse(frame_pulse)
  );

  adpll_lock_det #(.ERR_W(ERR_W), .LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(srst_n), .err_valid(err_valid), .err(pd_err),
    .thresh(lock_thresh), .need(lock_count), .locked(locked)
  );

endmodule

// File: rtl/adpll_checker.sv
module adpll_checker #(
  parameter int ACC_W    = 16,
  parameter int ERR_W    = 8,
  parameter int NOM_WORD = 16384
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    holdover,
  input logic                    freerun,
  input logic [ERR_W-2:0]        pd_limit,
  input logic [ERR_W-2:0]        lock_thresh,
  input logic                    err_valid,
  input logic signed [ERR_W-1:0] err,
  input logic                    locked,
  input logic [ACC_W-1:0]        freq_word,
  input logic                    dco_clk,
  input logic                    div0,
  input logic                    fb_tick,
  input logic                    frame_pulse
);

  logic [ERR_W-1:0] mag;
  always_comb mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);

  p_div_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div0) |-> $rose(dco_clk));

  p_frame_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  p_fb_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> !fb_tick);

  p_freerun_nominal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(freerun) |-> (freq_word == ACC_W'(NOM_WORD)));

  p_holdover_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !freerun) |=> $stable(freq_word));

  p_err_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (mag <= {1'b0, pd_limit}));

  p_unlock_on_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && (mag >= {1'b0, lock_thresh})) |=> !locked);

  p_lock_on_measure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(err_valid));

endmodule

bind adpll_top adpll_checker #(
  .ACC_W(ACC_W), .ERR_W(ERR_W), .NOM_WORD(NOM_WORD)
) u_adpll_chk (
  .clk(clk), .rst_n(srst_n), .holdover(holdover), .freerun(freerun),
  .pd_limit(pd_limit), .lock_thresh(lock_thresh), .err_valid(err_valid),
  .err(pd_err), .locked(locked), .freq_word(freq_word), .dco_clk(dco_clk),
  .div0(div_clk[0]), .fb_tick(fb_tick), .frame_pulse(frame_pulse)
);

// File: tb/tb_adpll_top.sv
module tb_adpll_top;

  localparam int ACC_W = 16;
  localparam int NOM   = 16384;
  localparam int ERR_W = 8;

  logic              clk, rst_n, ref_in, holdover, freerun;
  logic [1:0]        fsel;
  logic [ERR_W-2:0]  pd_limit, lock_thresh;
  logic [7:0]        lock_count;
  logic              dco_clk, fb_tick, frame_pulse, locked;
  logic [2:0]        div_clk;
  logic [ACC_W-1:0]  freq_word;

  adpll_top #(
    .ACC_W(ACC_W), .NOM_WORD(NOM), .NUM_DIV(3), .CNT_W(16),
    .FB_DIV_FRM(16), .FB_DIV_T1(12), .FB_DIV_E1(8), .FRAME_DIV(16),
    .ERR_W(ERR_W), .LOCK_W(8), .KP_SHIFT(6), .LPF_SHIFT(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fsel(fsel),
    .holdover(holdover), .freerun(freerun), .pd_limit(pd_limit),
    .lock_thresh(lock_thresh), .lock_count(lock_count), .dco_clk(dco_clk),
    .div_clk(div_clk), .fb_tick(fb_tick), .frame_pulse(frame_pulse),
    .locked(locked), .freq_word(freq_word)
  );

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];
  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit ref_en = 0;
  int ref_hi = 16;
  int ref_lo = 16;

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // reference generator, driven on falling edges
  initial begin
    ref_in = 1'b0;
    forever begin
      @(negedge clk);
      if (ref_en) begin
        repeat (ref_lo - 1) @(negedge clk);
        ref_in = 1'b1;
        repeat (ref_hi) @(negedge clk);
        ref_in = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_cmp++;
        if (e.val != a.val) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", e.req, a.val, e.val);
        end
      end
    end
  end

  task automatic push_chk(input string req, input int expv, input int actv);
    item_t e, a;
    e.req = req; e.val = expv;
    a.req = req; a.val = actv;
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  function automatic bit sig(input int sel);
    case (sel)
      0: return dco_clk;
      1: return div_clk[0];
      2: return div_clk[1];
      3: return div_clk[2];
      4: return fb_tick;
      default: return frame_pulse;
    endcase
  endfunction

  task automatic interval(input int sel, output int n);
    bit prev, cur;
    int c;
    c = 0;
    prev = sig(sel);
    forever begin
      @(negedge clk); cur = sig(sel);
      if (cur && !prev) break;
      prev = cur;
    end
    prev = cur;
    forever begin
      @(negedge clk); c++; cur = sig(sel);
      if (cur && !prev) break;
      prev = cur;
    end
    n = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int fw0;
    rst_n = 1'b1; holdover = 1'b0; freerun = 1'b1; fsel = 2'b10;
    pd_limit = 7'd15; lock_thresh = 7'd20; lock_count = 8'd4;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    push_chk("R1 dco_clk", 0, dco_clk);
    push_chk("R1 div_clk", 0, div_clk);
    push_chk("R1 fb_tick", 0, fb_tick);
    push_chk("R1 frame_pulse", 0, frame_pulse);
    push_chk("R1 locked", 0, locked);
    push_chk("R1 freq_word", NOM, freq_word);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2 oscillator period at the nominal word
    interval(0, n); push_chk("R2 dco period", 4, n);
    // R3 divided clocks
    interval(1, n); push_chk("R3 div0 period", 8, n);
    interval(2, n); push_chk("R3 div1 period", 16, n);
    interval(3, n); push_chk("R3 div2 period", 32, n);
    // R4 frame pulse spacing and width
    interval(5, n); push_chk("R4 frame period", 64, n);
    @(negedge clk); push_chk("R4 frame width", 0, frame_pulse);
    // R5 feedback ratio per rate code
    fsel = 2'b00; repeat (150) @(negedge clk);
    interval(4, n); push_chk("R5 fsel 00", 64, n);
    fsel = 2'b01; repeat (150) @(negedge clk);
    interval(4, n); push_chk("R5 fsel 01", 48, n);
    fsel = 2'b10; repeat (150) @(negedge clk);
    interval(4, n); push_chk("R5 fsel 10", 32, n);
    fsel = 2'b11; repeat (150) @(negedge clk);
    interval(4, n); push_chk("R5 fsel 11 reserved", 64, n);
    // R6 freerun word
    push_chk("R6 freerun word", NOM, freq_word);

    // R9 lock after lock_count good periods, drop on a bad one
    fsel = 2'b10;
    repeat (150) @(negedge clk);
    ref_hi = 16; ref_lo = 16; ref_en = 1;
    repeat (40) @(negedge clk);
    push_chk("R9 not yet locked", 0, locked);
    repeat (400) @(negedge clk);
    push_chk("R9 locked", 1, locked);
    lock_thresh = 7'd0;
    repeat (100) @(negedge clk);
    push_chk("R9 unlock at zero threshold", 0, locked);
    lock_thresh = 7'd20;

    // R10 closed loop with a faster reference
    ref_hi = 15; ref_lo = 16;
    freerun = 1'b0;
    repeat (20000) @(negedge clk);
    push_chk("R10 word above nominal", 1, int'(freq_word > ACC_W'(NOM)));
    push_chk("R8 word within bound", 1, int'(freq_word <= ACC_W'(NOM + 15 * 64)));

    // R7 holdover freezes the word
    holdover = 1'b1;
    repeat (2) @(negedge clk);
    fw0 = freq_word;
    ref_hi = 20; ref_lo = 20;
    repeat (3000) @(negedge clk);
    push_chk("R7 holdover word", fw0, freq_word);
    ref_en = 0;
    repeat (500) @(negedge clk);
    push_chk("R7 holdover without reference", fw0, freq_word);

    // R6 freerun overrides holdover
    freerun = 1'b1;
    repeat (2) @(negedge clk);
    push_chk("R6 freerun after holdover", NOM, freq_word);

    repeat (60) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule